// File: doc/BRIEF.md
# Dual-Source Baud Tick Generator

This block produces the bit-rate tick that paces a serial transmitter and receiver. The rate comes from one of two sources: a crystal-derived clock or a peripheral clock. Both arrive as enable pulses on a single common system clock. One 32-bit setting word selects the source, holds a 23-bit divide value N and carries a bit that turns the divider on. The selected source first passes through a fixed prescaler and then through a divide-by-(N+1) counter. The prescaler divides by 3 for the crystal source and by 4 for the peripheral source.

Software computes N from the clock frequency and the wanted bit rate, and writes the word. A 24 MHz crystal with N = 68 gives about 115200 baud. Every write restarts the prescaler and the divider from zero, so the first tick after a write comes one whole period later. The output is a pulse one system clock wide.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset the setting word is all zero and `baud_tick` stays low, whatever the source enables do.
- R2: While bit 23 (divider on) of the last written word is 0, `baud_tick` never rises.
- R3: When bit 24 is 1, the crystal source is used. Ticks come after every 3*(N+1) cycles in which `xtal_en` is high, and `pclk_en` has no effect.
- R4: When bit 24 is 0, the peripheral source is used. Ticks come after every 4*(N+1) cycles in which `pclk_en` is high, and `xtal_en` has no effect.
- R5: N is taken from bits 22:0 of the written word. N = 0 gives one tick per prescaler period.
- R6: A write clears both counters. No tick appears in the cycle after the write, and the first tick follows a full period of source enables counted from the write.
- R7: `baud_tick` is high for exactly one system clock cycle at a time.
- R8: Bits 31:25 of the written word have no effect on the tick rate.
- R9: Cycles in which the selected source enable is low are not counted, so gaps in the enable stretch the period without changing the enable count.
- R10: A tick is registered. It is visible in the cycle after the clock edge that accepted the last enable of the period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the setting word |
| cfg_wdata | input | 32 | Setting word: [22:0] N, [23] divider on, [24] crystal select |
| xtal_en | input | 1 | Crystal source enable pulse |
| pclk_en | input | 1 | Peripheral source enable pulse |
| baud_tick | output | 1 | One-cycle bit-rate tick |

## Verification
The checker holds on every cycle that a tick is never two cycles wide and never appears while the divider is off. It also holds that no tick follows a write in the next cycle, and that every tick comes one cycle after an enable of the selected source. The exact period is shown only by the bench's scenarios: 3*(N+1) or 4*(N+1) enables. So are the restart after a mid-period write, the indifference to the other source and the upper word bits, and the stretching of the period by gaps in the enable.

// File: rtl/baud_pkg.sv
package baud_pkg;
  // Source chosen by the crystal-select field
  typedef enum logic {
    SRC_PERIPH = 1'b0,
    SRC_XTAL   = 1'b1
  } baud_src_e;
endpackage

// File: rtl/baud_cfg_reg.sv
module baud_cfg_reg #(
  parameter int REG_W = 32,
  parameter int DIV_W = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  output logic [DIV_W-1:0] div_n,
  output logic             div_on,
  output baud_pkg::baud_src_e src
);
  localparam int ON_BIT  = DIV_W;
  localparam int SEL_BIT = DIV_W + 1;

  logic [DIV_W-1:0]    n_q, n_d;
  logic                on_q, on_d;
  baud_pkg::baud_src_e src_q, src_d;

  // Upper bits of the word are reserved
  logic unused_rsvd;
  assign unused_rsvd = ^wdata[REG_W-1:SEL_BIT+1];

  always_comb begin
    n_d   = n_q;
    on_d  = on_q;
    src_d = src_q;
    if (wr) begin
      n_d   = wdata[DIV_W-1:0];
      on_d  = wdata[ON_BIT];
      src_d = baud_pkg::baud_src_e'(wdata[SEL_BIT]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q   <= '0;
      on_q  <= 1'b0;
      src_q <= baud_pkg::SRC_PERIPH;
    end else if (wr) begin
      n_q   <= n_d;
      on_q  <= on_d;
      src_q <= src_d;
    end
  end

  assign div_n  = n_q;
  assign div_on = on_q;
  assign src    = src_q;
endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
  parameter int XTAL_PRE   = 3,
  parameter int PERIPH_PRE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  input  baud_pkg::baud_src_e src,
  input  logic xtal_en,
  input  logic pclk_en,
  output logic pre_fire
);
  localparam int MAXP = (XTAL_PRE > PERIPH_PRE) ? XTAL_PRE : PERIPH_PRE;
  localparam int PW   = (MAXP > 1) ? $clog2(MAXP) : 1;
  localparam logic [PW-1:0] XT_LAST = PW'(XTAL_PRE - 1);
  localparam logic [PW-1:0] PE_LAST = PW'(PERIPH_PRE - 1);

  logic [PW-1:0] cnt_q, cnt_d;
  logic [PW-1:0] last;
  logic          src_en;
  logic          at_last;

  assign src_en = (src == baud_pkg::SRC_XTAL) ? xtal_en : pclk_en;

  generate
    if (XTAL_PRE == PERIPH_PRE) begin : g_same
      assign last = XT_LAST;
    end else begin : g_mux
      assign last = (src == baud_pkg::SRC_XTAL) ? XT_LAST : PE_LAST;
    end
  endgenerate

  assign at_last  = (cnt_q == last);
  assign pre_fire = run && !clr && src_en && at_last;

  always_comb begin
    cnt_d = cnt_q;
    if (clr || !run)  cnt_d = '0;
    else if (src_en)  cnt_d = at_last ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/baud_divider.sv
module baud_divider #(
  parameter int DIV_W = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic             step,
  input  logic [DIV_W-1:0] div_n,
  output logic             div_fire
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             at_end;

  assign at_end   = (cnt_q == div_n);
  assign div_fire = run && !clr && step && at_end;

  always_comb begin
    cnt_d = cnt_q;
    if (clr || !run) cnt_d = '0;
    else if (step)   cnt_d = at_end ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int REG_W      = 32,
  parameter int DIV_W      = 23,
  parameter int XTAL_PRE   = 3,
  parameter int PERIPH_PRE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [REG_W-1:0] cfg_wdata,
  input  logic             xtal_en,
  input  logic             pclk_en,
  output logic             baud_tick
);
  logic [DIV_W-1:0]    div_n;
  logic                div_on;
  baud_pkg::baud_src_e src;
  logic                pre_fire;
  logic                div_fire;
  logic                tick_q, tick_d;

  baud_cfg_reg #(.REG_W(REG_W), .DIV_W(DIV_W)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (cfg_wr),
    .wdata  (cfg_wdata),
    .div_n  (div_n),
    .div_on (div_on),
    .src    (src)
  );

  baud_prescaler #(.XTAL_PRE(XTAL_PRE), .PERIPH_PRE(PERIPH_PRE)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (cfg_wr),
    .run      (div_on),
    .src      (src),
    .xtal_en  (xtal_en),
    .pclk_en  (pclk_en),
    .pre_fire (pre_fire)
  );

  baud_divider #(.DIV_W(DIV_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (cfg_wr),
    .run      (div_on),
    .step     (pre_fire),
    .div_n    (div_n),
    .div_fire (div_fire)
  );

  assign tick_d = div_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_q <= 1'b0;
    else        tick_q <= tick_d;
  end

  assign baud_tick = tick_q;
endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk #(
  parameter int REG_W = 32,
  parameter int DIV_W = 23
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr,
  input logic [REG_W-1:0] cfg_wdata,
  input logic             xtal_en,
  input logic             pclk_en,
  input logic             baud_tick
);
  logic on_sh, xs_sh;
  logic unused_bits;
  assign unused_bits = ^{cfg_wdata[REG_W-1:DIV_W+2], cfg_wdata[DIV_W-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_sh <= 1'b0;
      xs_sh <= 1'b0;
    end else if (cfg_wr) begin
      on_sh <= cfg_wdata[DIV_W];
      xs_sh <= cfg_wdata[DIV_W+1];
    end
  end

  // R2
  off_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !on_sh |-> !baud_tick);

  // R7
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |=> !baud_tick);

  // R6
  write_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> !baud_tick);

  // R3
  xtal_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_tick && xs_sh) |-> $past(xtal_en));

  // R4
  periph_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_tick && !xs_sh) |-> $past(pclk_en));
endmodule

bind baud_tick_gen baud_tick_gen_chk #(.REG_W(REG_W), .DIV_W(DIV_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_wr    (cfg_wr),
  .cfg_wdata (cfg_wdata),
  .xtal_en   (xtal_en),
  .pclk_en   (pclk_en),
  .baud_tick (baud_tick)
);

// File: tb/baud_tick_gen_tb.sv
module baud_tick_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] ON  = 32'h0080_0000;
  localparam logic [31:0] XS  = 32'h0100_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr;
  logic [31:0] cfg_wdata;
  logic        xtal_en;
  logic        pclk_en;
  logic        baud_tick;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  baud_tick_gen u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_wdata (cfg_wdata),
    .xtal_en   (xtal_en),
    .pclk_en   (pclk_en),
    .baud_tick (baud_tick)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [31:0] w);
    @(negedge clk);
    xtal_en = 0; pclk_en = 0;
    cfg_wr = 1; cfg_wdata = w;
    @(negedge clk);
    cfg_wr = 0;
    check("R6 no tick after write", baud_tick, 0);
  endtask

  // Drives the selected source every `every` cycles, the other one always
  // high; records the enable count at the first two ticks.
  task automatic measure(input bit sx, input int every, input int max_en,
                         output int t1, output int t2, output int nt);
    int n_en = 0;
    bit prev = 0;
    t1 = -1; t2 = -1; nt = 0;
    for (int c = 0; c < max_en*every + 3; c++) begin
      @(negedge clk);
      if (baud_tick) begin
        check("R7 one-cycle tick", int'(prev), 0);
        nt++;
        if (nt == 1) t1 = n_en;
        else if (nt == 2) t2 = n_en;
      end
      prev = baud_tick;
      if ((c % every) == 0 && n_en < max_en) begin
        if (sx) xtal_en = 1; else pclk_en = 1;
        n_en++;
      end else begin
        if (sx) xtal_en = 0; else pclk_en = 0;
      end
      if (sx) pclk_en = 1; else xtal_en = 1;
    end
    @(negedge clk);
    xtal_en = 0; pclk_en = 0;
  endtask

  task automatic t_reset;
    rst_n = 0; cfg_wr = 0; cfg_wdata = '0; xtal_en = 0; pclk_en = 0;
    repeat (3) @(negedge clk);
    check("R1 tick low in reset", baud_tick, 0);
    rst_n = 1;
    xtal_en = 1; pclk_en = 1;
    begin
      int seen = 0;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (baud_tick) seen++;
      end
      check("R1 no tick after reset", seen, 0);
    end
    xtal_en = 0; pclk_en = 0;
  endtask

  task automatic t_disabled;
    int t1, t2, nt;
    write_cfg(XS | 32'd0);
    measure(1, 1, 40, t1, t2, nt);
    check("R2 crystal off no tick", nt, 0);
    write_cfg(32'd0);
    measure(0, 1, 40, t1, t2, nt);
    check("R2 periph off no tick", nt, 0);
  endtask

  task automatic t_xtal;
    int t1, t2, nt;
    write_cfg(ON | XS | 32'd4);
    measure(1, 1, 31, t1, t2, nt);
    check("R3 first tick N=4", t1, 15);
    check("R3 second tick N=4", t2, 30);
    check("R10 tick count", nt, 2);
  endtask

  task automatic t_xtal_example;
    int t1, t2, nt;
    write_cfg(ON | XS | 32'd68);
    measure(1, 1, 415, t1, t2, nt);
    check("R5 N=68 first", t1, 207);
    check("R5 N=68 second", t2, 414);
  endtask

  task automatic t_periph_gaps;
    int t1, t2, nt;
    write_cfg(ON | 32'd2);
    measure(0, 3, 25, t1, t2, nt);
    check("R4 first tick N=2", t1, 12);
    check("R9 gapped second tick", t2, 24);
  endtask

  task automatic t_periph_n0;
    int t1, t2, nt;
    write_cfg(ON | 32'd0);
    measure(0, 1, 9, t1, t2, nt);
    check("R5 N=0 first", t1, 4);
    check("R5 N=0 second", t2, 8);
    check("R4 N=0 count", nt, 2);
  endtask

  task automatic t_restart;
    int t1, t2, nt;
    write_cfg(ON | XS | 32'd3);
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      xtal_en = 1;
    end
    @(negedge clk);
    xtal_en = 0;
    check("R6 no early tick", baud_tick, 0);
    write_cfg(ON | XS | 32'd3);
    measure(1, 1, 25, t1, t2, nt);
    check("R6 full period after rewrite", t1, 12);
    check("R6 second after rewrite", t2, 24);
  endtask

  task automatic t_upper_bits;
    int t1, t2, nt;
    write_cfg(32'hFE00_0000 | ON | XS | 32'd1);
    measure(1, 1, 13, t1, t2, nt);
    check("R8 reserved bits first", t1, 6);
    check("R8 reserved bits second", t2, 12);
  endtask

  initial begin
    t_reset();
    t_disabled();
    t_xtal();
    t_xtal_example();
    t_periph_gaps();
    t_periph_n0();
    t_restart();
    t_upper_bits();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule